// File: doc/BRIEF.md
# Configuration Stream Command Parser

This block sits at the front of a device configuration path. It takes configuration bytes one at a time over a valid/ready handshake. First it looks for the start marker. It throws away any leading text region and any bytes that come before the marker. Once the marker has been found, it reads a sequence of commands. Each command is an opcode byte, a 24-bit information field, an optional 32-bit payload and an optional 16-bit checksum. Single 0xFF bytes between commands are treated as filler.

Recognised commands have these effects:
- They load the control and user-code registers.
- They check the device identity against a parameter.
- They raise flags for frame-address reset and security.
- They end the stream when the done command arrives.

When the frame-programming opcode arrives, the block passes the stream on to a separate frame receiver. A companion accumulator keeps the running checksum. The parser tells it when to clear and when to check. Three conditions send the parser to an error state that lasts until reset: an unknown opcode, a wrong identity, or a bad checksum.

Top module: `cfg_stream_parser`

## Requirements
- R1: After reset, `in_ready` is 1. All registered outputs are 0: `ctrl0_q`, `usercode_q`, `secure_q`, `id_ok_q`, `addr_rst_pulse`, `done_q`, `frame_go`, `frame_setup` and `fault`. `fault_cause` is 0, which means no fault.
- R2: Before sync, the bytes FF 00 open a text region and the bytes 00 FF close it. Every byte inside the region is discarded. No byte in the region can start sync, and none is decoded as a command.
- R3: Commands are decoded only after the four-byte marker FF FF BD B3 has been received in order. Bytes that come earlier, including bytes that look like opcodes, are ignored.
- R4: Once synced, a 0xFF byte in the opcode position is consumed alone as filler. It has no information field, and it is not included in the checksum.
- R5: Every command byte other than filler is fed into a CRC-16 accumulator. That covers the opcode, the three information bytes and any payload bytes. The CRC uses polynomial 0x8005, starts from 0, processes bits MSB first and has no final XOR. If bit 7 of the first information byte is set, a big-endian checksum follows the payload. The checksum must equal the accumulated value. A command that carries a checksum takes effect only after the checksum matches. The accumulator restarts at sync and after every checksum.
- R6: If a checksum does not match, the parser enters the fault state with `fault_cause` = 3. That command has no effect.
- R7: Opcode 0x3B clears the accumulator, so the next checksum covers only the bytes sent after it.
- R8: Opcode 0xE2 carries a 32-bit big-endian identity. If it equals `DEVICE_ID`, `id_ok_q` is set. Otherwise the parser enters the fault state with `fault_cause` = 2.
- R9: Opcode 0x22 loads its 32-bit big-endian payload into `ctrl0_q`. Opcode 0xC2 loads its payload into `usercode_q`. Both registers hold their values until reset.
- R10: Opcode 0x46 raises `addr_rst_pulse` for exactly one cycle. Opcode 0xCE sets `secure_q`, which stays set until reset.
- R11: Opcode 0x5E sets `done_q` and drops `in_ready`. Any bytes offered after that are not accepted and change no output.
- R12: Opcode 0x82 is followed by its 24-bit setup field. After that field, `frame_go` goes high, `frame_setup` holds the field and `in_ready` drops. Bit 23 of this field does not add a checksum.
- R13: Any opcode outside the set 0xFF, 0x3B, 0x46, 0xCE, 0x5E, 0xE2, 0x22, 0xC2, 0x82 enters the fault state with `fault_cause` = 1. In the fault state, `fault` stays high, `in_ready` stays low and the cause stays fixed until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 8 | Configuration byte |
| in_valid | input | 1 | `in_data` holds a byte |
| in_ready | output | 1 | Parser accepts a byte this cycle |
| ctrl0_q | output | 32 | Control register 0 |
| usercode_q | output | 32 | User code register |
| secure_q | output | 1 | Security flag, set until reset |
| id_ok_q | output | 1 | Identity check passed |
| addr_rst_pulse | output | 1 | One-cycle frame-address reset strobe |
| done_q | output | 1 | End-of-stream command seen |
| frame_go | output | 1 | Stream handed to the frame receiver |
| frame_setup | output | 24 | Setup field of the frame command |
| fault | output | 1 | Error state, held until reset |
| fault_cause | output | 2 | 0 none, 1 unknown opcode, 2 identity mismatch, 3 checksum mismatch |

## Verification
The bench puts look-alike bytes in front of the marker, including an opcode-like 0x5E and text characters that are not valid opcodes. A parser that synced too early would either set done or fault on these bytes. It then sends a command stream that sets up a non-zero accumulator, clears it with 0x3B, and follows with a checksummed command. If the clear were missing, that command would end in a checksum fault. A checksum with one bit flipped must leave the user code untouched. A wrong identity must fault with its own cause code. After done, after a fault and after the frame hand-off, the bench offers more bytes. A parser that kept accepting them would let those bytes overwrite the control register.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

   typedef enum logic [2:0] {
      ST_HUNT  = 3'd0,
      ST_OPC   = 3'd1,
      ST_INFO  = 3'd2,
      ST_PAY   = 3'd3,
      ST_CRC   = 3'd4,
      ST_FRAME = 3'd5,
      ST_DONE  = 3'd6,
      ST_FAULT = 3'd7
   } cfgp_state_e;

   typedef enum logic [1:0] {
      FLT_NONE   = 2'd0,
      FLT_OPCODE = 2'd1,
      FLT_ID     = 2'd2,
      FLT_CRC    = 2'd3
   } cfgp_fault_e;

   localparam logic [7:0] OPC_FILL    = 8'hFF;
   localparam logic [7:0] OPC_CRC_CLR = 8'h3B;
   localparam logic [7:0] OPC_ADDR    = 8'h46;
   localparam logic [7:0] OPC_SECURE  = 8'hCE;
   localparam logic [7:0] OPC_FINISH  = 8'h5E;
   localparam logic [7:0] OPC_ID_CHK  = 8'hE2;
   localparam logic [7:0] OPC_CTRL0   = 8'h22;
   localparam logic [7:0] OPC_USER    = 8'hC2;
   localparam logic [7:0] OPC_FRAMES  = 8'h82;

   typedef struct packed {
      logic known;
      logic filler;
      logic has_word;
   } cfgp_opc_t;

   function automatic cfgp_opc_t cfgp_decode(input logic [7:0] b);
      cfgp_opc_t d;
      d = '{known: 1'b1, filler: 1'b0, has_word: 1'b0};
      case (b)
         OPC_FILL:                        d.filler   = 1'b1;
         OPC_CRC_CLR, OPC_ADDR, OPC_SECURE,
         OPC_FINISH, OPC_FRAMES:          d.has_word = 1'b0;
         OPC_ID_CHK, OPC_CTRL0, OPC_USER: d.has_word = 1'b1;
         default:                         d.known    = 1'b0;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/cfgp_crc.sv
module cfgp_crc #(
   parameter int            CRC_W = 16,
   parameter logic [15:0]   POLY  = 16'h8005,
   parameter logic [15:0]   INIT  = 16'h0000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       feed,
   input  logic       chk,
   input  logic [7:0] data,
   output logic       res_zero
);
   localparam logic [CRC_W-1:0] P = POLY[CRC_W-1:0];
   localparam logic [CRC_W-1:0] I = INIT[CRC_W-1:0];

   if (CRC_W < 8 || CRC_W > 16) begin : g_bad_w
      $error("cfgp_crc: CRC_W must be 8..16");
   end

   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] stage [0:8];

   assign stage[0] = crc_q;
   for (genvar i = 0; i < 8; i++) begin : g_bit
      logic fb;
      assign fb = stage[i][CRC_W-1] ^ data[7-i];
      assign stage[i+1] = {stage[i][CRC_W-2:0], 1'b0} ^ (fb ? P : '0);
   end

   assign res_zero = (stage[8] == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          crc_q <= I;
      else if (clr || chk) crc_q <= I;
      else if (feed)       crc_q <= stage[8];
   end

   AST_CRC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (chk && !clr) |=> (crc_q == I));   // R5
endmodule

// File: rtl/cfgp_sync.sv
module cfgp_sync #(
   parameter int                          PRE_BYTES = 4,
   parameter logic [PRE_BYTES*8-1:0]      PREAMBLE  = 32'hFFFF_BDB3,
   parameter logic [7:0]                  OPEN_A    = 8'hFF,
   parameter logic [7:0]                  OPEN_B    = 8'h00,
   parameter logic [7:0]                  CLOSE_A   = 8'h00,
   parameter logic [7:0]                  CLOSE_B   = 8'hFF
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic [7:0] data,
   output logic       hit
);
   localparam int PRE_W = PRE_BYTES * 8;

   if (PRE_BYTES < 1 || PRE_BYTES > 8) begin : g_bad_len
      $error("cfgp_sync: PRE_BYTES must be 1..8");
   end

   logic       note_q;
   logic [7:0] last_q;
   logic       open_s, close_s;
   logic [PRE_W-1:0] window;

   assign open_s  = en && !note_q && (last_q == OPEN_A)  && (data == OPEN_B);
   assign close_s = en &&  note_q && (last_q == CLOSE_A) && (data == CLOSE_B);

   if (PRE_BYTES > 1) begin : g_hist
      localparam int HW = PRE_W - 8;
      logic [HW-1:0] hist_q;
      logic [HW+7:0] cat;
      assign cat    = {hist_q, data};
      assign window = cat;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       hist_q <= '0;
         else if (close_s) hist_q <= '0;
         else if (en)      hist_q <= cat[HW-1:0];
      end
   end else begin : g_nohist
      assign window = data;
   end

   assign hit = en && !note_q && (window == PREAMBLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         note_q <= 1'b0;
         last_q <= 8'h00;
      end else if (en) begin
         if (open_s)       note_q <= 1'b1;
         else if (close_s) note_q <= 1'b0;
         last_q <= close_s ? 8'h00 : data;
      end
   end

   AST_NOTE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      close_s |=> !note_q);   // R2
endmodule

// File: rtl/cfgp_word.sv
module cfgp_word #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         shift,
   input  logic [7:0]   data,
   output logic [W-1:0] word_q,
   output logic [W-1:0] word_next
);
   if (W % 8 != 0 || W < 8) begin : g_bad_w
      $error("cfgp_word: W must be a multiple of 8");
   end

   logic [W+7:0] cat;
   assign cat       = {word_q, data};
   assign word_next = cat[W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     word_q <= '0;
      else if (clr)   word_q <= '0;
      else if (shift) word_q <= word_next;
   end
endmodule

// File: rtl/cfg_stream_parser.sv
module cfg_stream_parser
   import cfgp_pkg::*;
#(
   parameter logic [31:0] DEVICE_ID = 32'h2A5C_7013,
   parameter int          WORD_W    = 32,
   parameter int          INFO_W    = 24,
   parameter int          CRC_W     = 16,
   parameter logic [15:0] CRC_POLY  = 16'h8005,
   parameter int          PRE_BYTES = 4,
   parameter logic [31:0] PREAMBLE  = 32'hFFFF_BDB3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        in_data,
   input  logic              in_valid,
   output logic              in_ready,
   output logic [WORD_W-1:0] ctrl0_q,
   output logic [WORD_W-1:0] usercode_q,
   output logic              secure_q,
   output logic              id_ok_q,
   output logic              addr_rst_pulse,
   output logic              done_q,
   output logic              frame_go,
   output logic [INFO_W-1:0] frame_setup,
   output logic              fault,
   output logic [1:0]        fault_cause
);
   localparam int WORD_BYTES = WORD_W / 8;
   localparam int INFO_BYTES = INFO_W / 8;
   localparam int CRC_BYTES  = CRC_W / 8;
   localparam int MAXB_A     = (WORD_BYTES > INFO_BYTES) ? WORD_BYTES : INFO_BYTES;
   localparam int MAXB       = (MAXB_A > CRC_BYTES) ? MAXB_A : CRC_BYTES;
   localparam int CNT_W      = (MAXB > 1) ? $clog2(MAXB) : 1;
   localparam logic [CNT_W-1:0] INFO_LAST = CNT_W'(INFO_BYTES - 1);
   localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_BYTES - 1);
   localparam logic [CNT_W-1:0] CRC_LAST  = CNT_W'(CRC_BYTES - 1);

   if (WORD_W % 8 != 0 || INFO_W % 8 != 0 || CRC_W % 8 != 0) begin : g_bad_align
      $error("cfg_stream_parser: field widths must be whole bytes");
   end
   if (WORD_W != 32) begin : g_bad_word
      $error("cfg_stream_parser: WORD_W must match DEVICE_ID width");
   end
   if (PRE_BYTES != 4) begin : g_bad_pre
      $error("cfg_stream_parser: PRE_BYTES must match PREAMBLE width");
   end

   cfgp_state_e state_q, state_n;
   cfgp_fault_e cause_q, cause_n;
   logic [CNT_W-1:0] cnt_q, cnt_n;
   logic [7:0]  op_q, op_n;
   logic        word_op_q, word_op_n;
   logic        flag_q, flag_n;
   cfgp_opc_t   dec;
   logic        acc;
   logic        sync_hit;
   logic        crc_clr, crc_feed, crc_chk, crc_ok;
   logic        info_clr, info_sh, pay_sh;
   logic        finish;
   logic [WORD_W-1:0] fin_word;
   logic [WORD_W-1:0] pay_q, pay_next;
   logic [INFO_W-1:0] info_q, info_next;
   logic        flag_now;

   assign in_ready = (state_q == ST_HUNT) || (state_q == ST_OPC) || (state_q == ST_INFO)
                  || (state_q == ST_PAY)  || (state_q == ST_CRC);
   assign acc      = in_valid && in_ready;
   assign dec      = cfgp_decode(in_data);
   assign flag_now = (cnt_q == '0) ? in_data[7] : flag_q;

   cfgp_sync #(.PRE_BYTES(PRE_BYTES), .PREAMBLE(PREAMBLE)) u_sync (
      .clk(clk), .rst_n(rst_n), .en(acc && (state_q == ST_HUNT)),
      .data(in_data), .hit(sync_hit)
   );

   cfgp_crc #(.CRC_W(CRC_W), .POLY(CRC_POLY), .INIT(16'h0000)) u_crc (
      .clk(clk), .rst_n(rst_n), .clr(crc_clr), .feed(crc_feed), .chk(crc_chk),
      .data(in_data), .res_zero(crc_ok)
   );

   cfgp_word #(.W(INFO_W)) u_info (
      .clk(clk), .rst_n(rst_n), .clr(info_clr), .shift(info_sh),
      .data(in_data), .word_q(info_q), .word_next(info_next)
   );

   cfgp_word #(.W(WORD_W)) u_pay (
      .clk(clk), .rst_n(rst_n), .clr(info_clr), .shift(pay_sh),
      .data(in_data), .word_q(pay_q), .word_next(pay_next)
   );

   always_comb begin
      state_n   = state_q;
      cause_n   = cause_q;
      cnt_n     = cnt_q;
      op_n      = op_q;
      word_op_n = word_op_q;
      flag_n    = flag_q;
      crc_clr   = 1'b0;
      crc_feed  = 1'b0;
      crc_chk   = 1'b0;
      info_clr  = 1'b0;
      info_sh   = 1'b0;
      pay_sh    = 1'b0;
      finish    = 1'b0;
      fin_word  = pay_q;
      case (state_q)
         ST_HUNT: if (acc && sync_hit) begin
            state_n = ST_OPC;
            crc_clr = 1'b1;
         end
         ST_OPC: if (acc && !dec.filler) begin
            if (!dec.known) begin
               state_n = ST_FAULT;
               cause_n = FLT_OPCODE;
            end else begin
               crc_feed  = 1'b1;
               info_clr  = 1'b1;
               op_n      = in_data;
               word_op_n = dec.has_word;
               cnt_n     = '0;
               state_n   = ST_INFO;
            end
         end
         ST_INFO: if (acc) begin
            crc_feed = 1'b1;
            info_sh  = 1'b1;
            if (cnt_q == '0) flag_n = in_data[7];
            if (cnt_q == INFO_LAST) begin
               cnt_n = '0;
               if (op_q == OPC_FRAMES)  state_n = ST_FRAME;
               else if (word_op_q)      state_n = ST_PAY;
               else if (flag_now)       state_n = ST_CRC;
               else                     finish  = 1'b1;
            end else begin
               cnt_n = cnt_q + 1'b1;
            end
         end
         ST_PAY: if (acc) begin
            crc_feed = 1'b1;
            pay_sh   = 1'b1;
            if (cnt_q == WORD_LAST) begin
               cnt_n = '0;
               if (flag_q) state_n = ST_CRC;
               else begin
                  finish   = 1'b1;
                  fin_word = pay_next;
               end
            end else begin
               cnt_n = cnt_q + 1'b1;
            end
         end
         ST_CRC: if (acc) begin
            crc_feed = 1'b1;
            if (cnt_q == CRC_LAST) begin
               cnt_n   = '0;
               crc_chk = 1'b1;
               if (!crc_ok) begin
                  state_n = ST_FAULT;
                  cause_n = FLT_CRC;
               end else begin
                  finish = 1'b1;
               end
            end else begin
               cnt_n = cnt_q + 1'b1;
            end
         end
         default: ;
      endcase
      if (finish) begin
         state_n = ST_OPC;
         case (op_q)
            OPC_FINISH:  state_n = ST_DONE;
            OPC_CRC_CLR: crc_clr = 1'b1;
            OPC_ID_CHK: if (fin_word != DEVICE_ID) begin
               state_n = ST_FAULT;
               cause_n = FLT_ID;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_HUNT;
         cause_q   <= FLT_NONE;
         cnt_q     <= '0;
         op_q      <= 8'h00;
         word_op_q <= 1'b0;
         flag_q    <= 1'b0;
      end else begin
         state_q   <= state_n;
         cause_q   <= cause_n;
         cnt_q     <= cnt_n;
         op_q      <= op_n;
         word_op_q <= word_op_n;
         flag_q    <= flag_n;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl0_q        <= '0;
         usercode_q     <= '0;
         secure_q       <= 1'b0;
         id_ok_q        <= 1'b0;
         addr_rst_pulse <= 1'b0;
         frame_setup    <= '0;
      end else begin
         addr_rst_pulse <= 1'b0;
         if (state_q == ST_INFO && acc && cnt_q == INFO_LAST && op_q == OPC_FRAMES)
            frame_setup <= info_next;
         if (finish) begin
            case (op_q)
               OPC_CTRL0:  ctrl0_q        <= fin_word;
               OPC_USER:   usercode_q     <= fin_word;
               OPC_SECURE: secure_q       <= 1'b1;
               OPC_ADDR:   addr_rst_pulse <= 1'b1;
               OPC_ID_CHK: id_ok_q        <= (fin_word == DEVICE_ID);
               default: ;
            endcase
         end
      end
   end

   assign done_q      = (state_q == ST_DONE);
   assign frame_go    = (state_q == ST_FRAME);
   assign fault       = (state_q == ST_FAULT);
   assign fault_cause = cause_q;

   AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> (fault && $stable(fault_cause)));   // R13
   AST_FAULT_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> !in_ready);   // R13
   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> (done_q && $stable(ctrl0_q) && $stable(usercode_q)));   // R11
   AST_DONE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !in_ready);   // R11
   AST_SECURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      secure_q |=> secure_q);   // R10
   AST_ADDR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      addr_rst_pulse |=> !addr_rst_pulse);   // R10
   AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      frame_go |=> (frame_go && $stable(frame_setup) && !in_ready));   // R12
   AST_CRC_FAULT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (fault && fault_cause == 2'd3) |-> $stable(usercode_q));   // R6
   AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fault, done_q, frame_go}));   // R11
endmodule

// File: tb/cfg_stream_parser_test.sv
module cfg_stream_parser_test;
   localparam logic [31:0] DEV = 32'h2A5C_7013;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  in_data = 8'h00;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] ctrl0_q, usercode_q;
   logic        secure_q, id_ok_q, addr_rst_pulse, done_q, frame_go, fault;
   logic [23:0] frame_setup;
   logic [1:0]  fault_cause;

   always #10 clk = ~clk;

   cfg_stream_parser #(.DEVICE_ID(DEV)) uut (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
      .in_ready(in_ready), .ctrl0_q(ctrl0_q), .usercode_q(usercode_q),
      .secure_q(secure_q), .id_ok_q(id_ok_q), .addr_rst_pulse(addr_rst_pulse),
      .done_q(done_q), .frame_go(frame_go), .frame_setup(frame_setup),
      .fault(fault), .fault_cause(fault_cause)
   );

   typedef struct {
      int          sel;
      logic [31:0] exp;
      string       req;
   } item_t;

   item_t       sbq[$];
   event        ev_chk, ev_drained;
   int          n_chk = 0;
   int          n_fail = 0;
   logic [15:0] crc_m = 16'h0000;
   bit          finished = 1'b0;

   function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
      logic [15:0] r;
      r = c;
      for (int i = 7; i >= 0; i--) begin
         if (r[15] ^ b[i]) r = {r[14:0], 1'b0} ^ 16'h8005;
         else              r = {r[14:0], 1'b0};
      end
      return r;
   endfunction

   function automatic logic [31:0] port_val(input int sel);
      case (sel)
         0:  return ctrl0_q;
         1:  return usercode_q;
         2:  return {31'd0, secure_q};
         3:  return {31'd0, id_ok_q};
         4:  return {31'd0, addr_rst_pulse};
         5:  return {31'd0, done_q};
         6:  return {31'd0, fault};
         7:  return {30'd0, fault_cause};
         8:  return {31'd0, frame_go};
         9:  return {8'd0, frame_setup};
         default: return {31'd0, in_ready};
      endcase
   endfunction

   // monitor: pops expected items and compares with the ports
   initial begin
      forever begin
         @(ev_chk);
         while (sbq.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = sbq.pop_front();
            act = port_val(it.sel);
            n_chk++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s: port %0d actual %h expected %h", it.req, it.sel, act, it.exp);
            end
         end
         ->ev_drained;
      end
   end

   task automatic expect_val(input int sel, input logic [31:0] exp, input string req);
      item_t it;
      it.sel = sel; it.exp = exp; it.req = req;
      sbq.push_back(it);
   endtask

   task automatic fire();
      ->ev_chk;
      @(ev_drained);
   endtask

   task automatic put(input logic [7:0] b, output bit took);
      int t;
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = b;
      t = 0;
      while (!in_ready && t < 8) begin
         @(negedge clk);
         t++;
      end
      took = in_ready;
      if (!took) in_valid = 1'b0;
   endtask

   task automatic put_b(input logic [7:0] b);
      bit took;
      put(b, took);
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic do_reset();
      in_valid = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic sync_up();
      put_b(8'hFF); put_b(8'hFF); put_b(8'hBD); put_b(8'hB3);
      crc_m = 16'h0000;
      for (int i = 0; i < 4; i++) put_b(8'hFF);
   endtask

   task automatic feed(input logic [7:0] b);
      crc_m = crc_step(crc_m, b);
      put_b(b);
   endtask

   // one command: opcode, info, optional word, checksum when info[23] set (not for 0x82)
   task automatic send_cmd(input logic [7:0] op, input logic [23:0] info,
                           input bit has_word, input logic [31:0] w, input bit good_crc);
      logic [15:0] c;
      feed(op);
      feed(info[23:16]); feed(info[15:8]); feed(info[7:0]);
      if (has_word) begin
         feed(w[31:24]); feed(w[23:16]); feed(w[15:8]); feed(w[7:0]);
      end
      if (info[23] && op != 8'h82) begin
         c = good_crc ? crc_m : (crc_m ^ 16'h0100);
         put_b(c[15:8]); put_b(c[7:0]);
         crc_m = 16'h0000;
      end
      if (op == 8'h3B) crc_m = 16'h0000;
      idle();
   endtask

   initial begin
      #(20ns * 150000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      bit took;
      do_reset();
      // R1 reset state
      expect_val(10, 1, "R1"); expect_val(0, 0, "R1"); expect_val(1, 0, "R1");
      expect_val(2, 0, "R1");  expect_val(5, 0, "R1"); expect_val(6, 0, "R1");
      expect_val(7, 0, "R1");  expect_val(8, 0, "R1"); expect_val(3, 0, "R1");
      fire();

      // R3: opcode-looking bytes before the marker are ignored
      put_b(8'h5E); put_b(8'h00); put_b(8'h00); put_b(8'h00);
      // R2: text region holding non-opcode characters and a stray 0x5E
      put_b(8'hFF); put_b(8'h00); put_b(8'h68); put_b(8'h69); put_b(8'h00);
      put_b(8'h5E); put_b(8'hBD); put_b(8'hB3); put_b(8'h00); put_b(8'h00); put_b(8'hFF);
      idle();
      expect_val(5, 0, "R3"); expect_val(6, 0, "R2"); expect_val(10, 1, "R2");
      fire();

      sync_up();
      send_cmd(8'h22, 24'h000000, 1'b1, 32'h4000_0000, 1'b1);
      expect_val(0, 32'h4000_0000, "R9"); expect_val(6, 0, "R4");
      fire();

      // R4 filler between commands, then checksummed user code (R5)
      put_b(8'hFF); put_b(8'hFF);
      send_cmd(8'hC2, 24'h800000, 1'b1, 32'h1234_5678, 1'b1);
      expect_val(1, 32'h1234_5678, "R5"); expect_val(6, 0, "R4");
      fire();

      send_cmd(8'h46, 24'h000000, 1'b0, 32'h0, 1'b1);
      expect_val(4, 1, "R10");
      fire();
      @(negedge clk);
      expect_val(4, 0, "R10");
      fire();

      send_cmd(8'hCE, 24'h000000, 1'b0, 32'h0, 1'b1);
      expect_val(2, 1, "R10");
      fire();

      send_cmd(8'hE2, 24'h000000, 1'b1, DEV, 1'b1);
      expect_val(3, 1, "R8"); expect_val(6, 0, "R8");
      fire();

      // R7: dirty the accumulator, clear it, then a checksummed load
      send_cmd(8'h22, 24'h000000, 1'b1, 32'hDEAD_0001, 1'b1);
      send_cmd(8'h3B, 24'h000000, 1'b0, 32'h0, 1'b1);
      send_cmd(8'h22, 24'h800000, 1'b1, 32'hA5A5_0001, 1'b1);
      expect_val(0, 32'hA5A5_0001, "R7"); expect_val(6, 0, "R7");
      expect_val(2, 1, "R10");
      fire();

      // R12 hand-off
      send_cmd(8'h82, 24'h910001, 1'b0, 32'h0, 1'b1);
      expect_val(8, 1, "R12"); expect_val(9, 32'h0091_0001, "R12");
      expect_val(10, 0, "R12"); expect_val(6, 0, "R12");
      fire();
      put(8'h22, took);
      expect_val(10, 0, "R12"); expect_val(0, 32'hA5A5_0001, "R12");
      fire();

      // R6 bad checksum
      do_reset(); sync_up();
      send_cmd(8'hC2, 24'h800000, 1'b1, 32'hCAFE_F00D, 1'b0);
      expect_val(6, 1, "R6"); expect_val(7, 3, "R6"); expect_val(1, 0, "R6");
      fire();
      put(8'h22, took);
      repeat (2) @(negedge clk);
      expect_val(6, 1, "R13"); expect_val(7, 3, "R13"); expect_val(10, 0, "R13");
      fire();

      // R8 identity mismatch
      do_reset(); sync_up();
      send_cmd(8'hE2, 24'h000000, 1'b1, DEV ^ 32'h1, 1'b1);
      expect_val(6, 1, "R8"); expect_val(7, 2, "R8"); expect_val(3, 0, "R8");
      fire();

      // R13 unknown opcode
      do_reset(); sync_up();
      put_b(8'h77); idle();
      expect_val(6, 1, "R13"); expect_val(7, 1, "R13"); expect_val(10, 0, "R13");
      fire();

      // R11 done, later bytes refused
      do_reset(); sync_up();
      send_cmd(8'h5E, 24'h000000, 1'b0, 32'h0, 1'b1);
      expect_val(5, 1, "R11"); expect_val(10, 0, "R11");
      fire();
      put(8'h22, took); put(8'h00, took); put(8'h00, took);
      repeat (2) @(negedge clk);
      expect_val(5, 1, "R11"); expect_val(0, 0, "R11"); expect_val(6, 0, "R11");
      fire();

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule